// File: doc/BRIEF.md
# Line-Matching Miss Queue for Data-Cache Loads

This block holds loads that missed the data cache until the next-level cache has returned their lines. A miss arrives from the last execute stage with a real address, a destination register tag and a thread number. It is written into a first-in, first-out queue. The oldest entry that has not been sent yet offers its request to the command-port arbiter of the next-level cache. An entry is retired once the second half of its 64-byte reload has been written. On retirement the block gives back the register tag so that waiting consumers can wake up.

The queue never merges requests. A new load miss is flushed instead of being queued when its line is already held by a valid entry. A store miss to such a line is flushed too. A load miss that arrives while every slot is occupied is flushed, and a held flush is raised. The held flush stays up until a slot is freed, so every load presented in that time is flushed as well.

Top module: `miss_line_queue`

## Requirements
- R1: After reset the queue is empty: `req_vld_o`, `ld_flush_o`, `st_flush_o` and `free_vld_o` are all low.
- R2: A load miss is queued when it is not line-matched, the queue is not full and no flush is held. Its line address, tag and thread can be seen on the request port from the next cycle.
- R3: `req_vld_o` shows the oldest entry that has not been sent. A cycle with both `req_vld_o` and `req_gnt_i` high marks that entry as sent, and the next unsent entry is offered in the following cycle.
- R4: A load miss is flushed in the same cycle (`ld_flush_o` high) and is not queued when its line address matches any valid entry, whether sent or unsent. The line address is real-address bits [ADDR_W-1:6].
- R5: A store miss raises `st_flush_o` in the same cycle when its line address matches any valid entry. Otherwise `st_flush_o` stays low.
- R6: A load miss that arrives while DEPTH entries are valid is flushed and sets the held flush. A slot freed in that same cycle does not make room for it.
- R7: While the held flush is set, `ld_flush_o` stays high and no load is queued. The held flush is cleared in the cycle after a free, so `ld_flush_o` follows only new hits from then on.
- R8: `rld_done_i` retires the oldest entry if it has been sent. In that same cycle `free_vld_o` pulses with the entry's tag and thread.
- R9: Address bits [5:0] play no part in matching. Two addresses that differ only in those bits count as the same line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_miss_vld_i | input | 1 | Load missed the data cache in the last execute stage |
| ld_addr_i | input | ADDR_W | Real address of the load |
| ld_tag_i | input | TAG_W | Destination register tag of the load |
| ld_tid_i | input | TID_W | Thread of the load |
| st_miss_vld_i | input | 1 | Store missed the data cache in the last execute stage |
| st_addr_i | input | ADDR_W | Real address of the store |
| req_vld_o | output | 1 | Oldest unsent entry requests the command port |
| req_line_o | output | ADDR_W-6 | Line address of the request |
| req_tag_o | output | TAG_W | Register tag of the request |
| req_tid_o | output | TID_W | Thread of the request |
| req_gnt_i | input | 1 | Command port granted to the request |
| rld_done_i | input | 1 | Second half of the oldest reload has been written |
| free_vld_o | output | 1 | An entry was retired |
| free_tag_o | output | TAG_W | Tag of the retired entry, used for wakeup |
| free_tid_o | output | TID_W | Thread of the retired entry |
| ld_flush_o | output | 1 | Flush for the load (line hit, full queue or held flush) |
| st_flush_o | output | 1 | Flush for the store (line hit) |

## Verification
A behavioural model built from a list of entries is compared with the block on every cycle. The stimulus runs in three patterns. A directed fill with grants held off forces the full flush. It also shows that the held flush persists until the first free and only then lets go. Random traffic over a few line addresses, with random low offset bits, produces many line hits against both sent and unsent entries. This separates real line matching from whole-address matching and from matching only unsent entries. Random traffic over a wide address range keeps hits rare, which exercises in-order issue, grant back-pressure and retirement while the queue is only partly full.

// File: rtl/mlq_pkg.sv
package mlq_pkg;
  localparam int unsigned LINE_BYTES = 64;
  localparam int unsigned LINE_OFS   = $clog2(LINE_BYTES);

  function automatic int unsigned ptr_inc(int unsigned p, int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/mlq_slot.sv
module mlq_slot #(
  parameter int unsigned LINE_W = 36,
  parameter int unsigned TAG_W  = 6,
  parameter int unsigned TID_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic              send_i,
  input  logic              free_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [TID_W-1:0]  tid_i,
  input  logic [LINE_W-1:0] ld_line_i,
  input  logic [LINE_W-1:0] st_line_i,
  output logic              vld_o,
  output logic              sent_o,
  output logic [LINE_W-1:0] line_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [TID_W-1:0]  tid_o,
  output logic              ld_hit_o,
  output logic              st_hit_o
);
  logic              vld_q, sent_q;
  logic [LINE_W-1:0] line_q;
  logic [TAG_W-1:0]  tag_q;
  logic [TID_W-1:0]  tid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      sent_q <= 1'b0;
      line_q <= '0;
      tag_q  <= '0;
      tid_q  <= '0;
    end else if (alloc_i) begin
      vld_q  <= 1'b1;
      sent_q <= 1'b0;
      line_q <= line_i;
      tag_q  <= tag_i;
      tid_q  <= tid_i;
    end else begin
      if (free_i) vld_q <= 1'b0;
      if (send_i) sent_q <= 1'b1;
    end
  end

  assign vld_o    = vld_q;
  assign sent_o   = sent_q;
  assign line_o   = line_q;
  assign tag_o    = tag_q;
  assign tid_o    = tid_q;
  // sent entries still match until retired
  assign ld_hit_o = vld_q && (line_q == ld_line_i);
  assign st_hit_o = vld_q && (line_q == st_line_i);

  p_alloc_free_slot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !vld_q);
  p_free_after_send_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_i |-> (vld_q && sent_q));
  p_send_once_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_i |-> (vld_q && !sent_q));
endmodule

// File: rtl/mlq_ptrs.sv
module mlq_ptrs #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             issue_i,
  input  logic             pop_i,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] iss_ptr_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o
);
  import mlq_pkg::*;

  logic [PTR_W-1:0] wr_q, iss_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      iss_q <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i)  wr_q  <= PTR_W'(ptr_inc(int'(wr_q), DEPTH));
      if (issue_i) iss_q <= PTR_W'(ptr_inc(int'(iss_q), DEPTH));
      if (pop_i)   rd_q  <= PTR_W'(ptr_inc(int'(rd_q), DEPTH));
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  assign wr_ptr_o  = wr_q;
  assign iss_ptr_o = iss_q;
  assign rd_ptr_o  = rd_q;
  assign cnt_o     = cnt_q;
  assign full_o    = (cnt_q == CNT_W'(DEPTH));

  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (cnt_q != CNT_W'(DEPTH)));
  p_no_underflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (cnt_q != '0));
endmodule

// File: rtl/miss_line_queue.sv
module miss_line_queue #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 42,
  parameter int unsigned TAG_W  = 6,
  parameter int unsigned TID_W  = 2,
  localparam int unsigned LINE_W = ADDR_W - mlq_pkg::LINE_OFS,
  localparam int unsigned PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_miss_vld_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [TAG_W-1:0]  ld_tag_i,
  input  logic [TID_W-1:0]  ld_tid_i,
  input  logic              st_miss_vld_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  output logic              req_vld_o,
  output logic [LINE_W-1:0] req_line_o,
  output logic [TAG_W-1:0]  req_tag_o,
  output logic [TID_W-1:0]  req_tid_o,
  input  logic              req_gnt_i,
  input  logic              rld_done_i,
  output logic              free_vld_o,
  output logic [TAG_W-1:0]  free_tag_o,
  output logic [TID_W-1:0]  free_tid_o,
  output logic              ld_flush_o,
  output logic              st_flush_o
);
  import mlq_pkg::*;

  logic [LINE_W-1:0] ld_line, st_line;
  logic [DEPTH-1:0]  s_vld, s_sent, s_ld_hit, s_st_hit, s_alloc, s_send, s_free;
  logic [LINE_W-1:0] s_line [DEPTH];
  logic [TAG_W-1:0]  s_tag  [DEPTH];
  logic [TID_W-1:0]  s_tid  [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, iss_ptr, rd_ptr;
  logic [CNT_W-1:0]  cnt;
  logic              full, ld_match, enq, issue, retire, hold_q;

  assign ld_line = ld_addr_i[ADDR_W-1:LINE_OFS];
  assign st_line = st_addr_i[ADDR_W-1:LINE_OFS];

  mlq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i, .rst_ni,
    .push_i   (enq),
    .issue_i  (issue),
    .pop_i    (retire),
    .wr_ptr_o (wr_ptr),
    .iss_ptr_o(iss_ptr),
    .rd_ptr_o (rd_ptr),
    .cnt_o    (cnt),
    .full_o   (full)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign s_alloc[i] = enq    && (wr_ptr  == PTR_W'(i));
    assign s_send[i]  = issue  && (iss_ptr == PTR_W'(i));
    assign s_free[i]  = retire && (rd_ptr  == PTR_W'(i));

    mlq_slot #(.LINE_W(LINE_W), .TAG_W(TAG_W), .TID_W(TID_W)) u_slot (
      .clk_i, .rst_ni,
      .alloc_i  (s_alloc[i]),
      .send_i   (s_send[i]),
      .free_i   (s_free[i]),
      .line_i   (ld_line),
      .tag_i    (ld_tag_i),
      .tid_i    (ld_tid_i),
      .ld_line_i(ld_line),
      .st_line_i(st_line),
      .vld_o    (s_vld[i]),
      .sent_o   (s_sent[i]),
      .line_o   (s_line[i]),
      .tag_o    (s_tag[i]),
      .tid_o    (s_tid[i]),
      .ld_hit_o (s_ld_hit[i]),
      .st_hit_o (s_st_hit[i])
    );
  end

  assign ld_match = |s_ld_hit;
  assign enq      = ld_miss_vld_i && !ld_match && !full && !hold_q;

  assign req_vld_o  = s_vld[iss_ptr] && !s_sent[iss_ptr];
  assign req_line_o = s_line[iss_ptr];
  assign req_tag_o  = s_tag[iss_ptr];
  assign req_tid_o  = s_tid[iss_ptr];
  assign issue      = req_vld_o && req_gnt_i;

  assign retire     = rld_done_i && s_vld[rd_ptr] && s_sent[rd_ptr];
  assign free_vld_o = retire;
  assign free_tag_o = s_tag[rd_ptr];
  assign free_tid_o = s_tid[rd_ptr];

  // held flush: set by a full-queue load, dropped after any retirement
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= 1'b0;
    else         hold_q <= (hold_q || (ld_miss_vld_i && full)) && !retire;
  end

  assign ld_flush_o = (ld_miss_vld_i && (ld_match || full)) || hold_q;
  assign st_flush_o = st_miss_vld_i && |s_st_hit;

  p_flush_no_alloc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_flush_o |=> (cnt == $past(cnt) - CNT_W'($past(retire))));
  p_full_sets_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_miss_vld_i && full && !retire) |=> hold_q);
  p_hold_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_vld_o |=> !hold_q);
  p_st_flush_needs_entry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_flush_o |-> (cnt != '0));
  p_empty_no_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == '0) |-> !req_vld_o);
endmodule

// File: tb/miss_line_queue_test.sv
module miss_line_queue_test;
  localparam int DEPTH = 8, ADDR_W = 42, TAG_W = 6, TID_W = 2, OFS = 6;
  localparam int LINE_W = ADDR_W - OFS;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5ns clk = ~clk;

  logic              ld_vld = 0, st_vld = 0, gnt = 0, rld = 0;
  logic [ADDR_W-1:0] ld_addr = '0, st_addr = '0;
  logic [TAG_W-1:0]  ld_tag = '0;
  logic [TID_W-1:0]  ld_tid = '0;
  logic              req_vld, free_vld, ld_flush, st_flush;
  logic [LINE_W-1:0] req_line;
  logic [TAG_W-1:0]  req_tag, free_tag;
  logic [TID_W-1:0]  req_tid, free_tid;

  miss_line_queue uut (
    .clk_i(clk), .rst_ni(rst_n),
    .ld_miss_vld_i(ld_vld), .ld_addr_i(ld_addr), .ld_tag_i(ld_tag), .ld_tid_i(ld_tid),
    .st_miss_vld_i(st_vld), .st_addr_i(st_addr),
    .req_vld_o(req_vld), .req_line_o(req_line), .req_tag_o(req_tag), .req_tid_o(req_tid),
    .req_gnt_i(gnt), .rld_done_i(rld),
    .free_vld_o(free_vld), .free_tag_o(free_tag), .free_tid_o(free_tid),
    .ld_flush_o(ld_flush), .st_flush_o(st_flush)
  );

  typedef struct { logic [LINE_W-1:0] line; logic [TAG_W-1:0] tag; logic [TID_W-1:0] tid; bit sent; } ent_t;
  ent_t q[$];
  bit   hold = 0;
  int   checks = 0, errors = 0;

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", r, act, exp, $time);
    end
  endtask

  function automatic bit hits(logic [LINE_W-1:0] l);
    foreach (q[i]) if (q[i].line == l) return 1;
    return 0;
  endfunction

  function automatic int first_unsent();
    foreach (q[i]) if (!q[i].sent) return i;
    return -1;
  endfunction

  // compare outputs with the model, then advance the model on the edge
  task automatic step();
    bit lm, full, fr; int u;
    #1;
    lm = hits(ld_addr[ADDR_W-1:OFS]);
    full = (q.size() == DEPTH);
    u = first_unsent();
    fr = rld && q.size() > 0 && q[0].sent;
    chk("R3 req_vld", 64'(req_vld), 64'(u >= 0));
    if (u >= 0) begin
      chk("R3 req_line", 64'(req_line), 64'(q[u].line));
      chk("R2 req_tag", 64'(req_tag), 64'(q[u].tag));
      chk("R2 req_tid", 64'(req_tid), 64'(q[u].tid));
    end
    chk("R4 R6 R7 R9 ld_flush", 64'(ld_flush), 64'((ld_vld && (lm || full)) || hold));
    chk("R5 st_flush", 64'(st_flush), 64'(st_vld && hits(st_addr[ADDR_W-1:OFS])));
    chk("R8 free_vld", 64'(free_vld), 64'(fr));
    if (fr) begin
      chk("R8 free_tag", 64'(free_tag), 64'(q[0].tag));
      chk("R8 free_tid", 64'(free_tid), 64'(q[0].tid));
    end
    @(posedge clk);
    if (u >= 0 && gnt) q[u].sent = 1;
    if (fr) void'(q.pop_front());
    if (ld_vld && !lm && !full && !hold)
      q.push_back('{ld_addr[ADDR_W-1:OFS], ld_tag, ld_tid, 1'b0});
    hold = (hold || (ld_vld && full)) && !fr;
    @(negedge clk);
  endtask

  task automatic drive(bit lv, logic [LINE_W-1:0] ll, bit sv, logic [LINE_W-1:0] sl, bit g, bit r);
    ld_vld = lv; ld_addr = {ll, 6'($urandom)};  // R9: random offset bits
    ld_tag = TAG_W'($urandom); ld_tid = TID_W'($urandom);
    st_vld = sv; st_addr = {sl, 6'($urandom)};
    gnt = g; rld = r && q.size() > 0 && q[0].sent;
    step();
  endtask

  initial begin
    #2_000_000ns;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 req_vld", 64'(req_vld), 0);
    chk("R1 ld_flush", 64'(ld_flush), 0);
    chk("R1 st_flush", 64'(st_flush), 0);
    chk("R1 free_vld", 64'(free_vld), 0);
    rst_n = 1;
    @(negedge clk);
    // directed fill without grants, then full flush and held flush (R6, R7)
    for (int i = 0; i < DEPTH; i++) drive(1, LINE_W'(100 + i), 0, '0, 0, 0);
    drive(1, LINE_W'(500), 0, '0, 0, 0);
    drive(0, '0, 1, LINE_W'(103), 0, 0);      // R5 store hit on unsent entry
    drive(1, LINE_W'(102), 0, '0, 1, 0);      // R4 line hit while full
    for (int i = 0; i < DEPTH; i++) drive(0, '0, 0, '0, 1, 0);
    drive(1, LINE_W'(101), 0, '0, 0, 0);      // R4 hit on sent entry
    drive(0, '0, 0, '0, 0, 1);                // R8 free, R7 hold clears next cycle
    drive(1, LINE_W'(600), 0, '0, 0, 0);      // R2 queued after hold drops
    for (int i = 0; i < 40; i++) drive(0, '0, 0, '0, 1, 1);
    // random traffic: narrow line pool (many hits) then wide pool
    for (int i = 0; i < 3000; i++) begin
      logic [LINE_W-1:0] pool;
      pool = (i < 1500) ? LINE_W'($urandom_range(0, 11)) : LINE_W'($urandom);
      drive($urandom_range(0, 99) < 50, pool,
            $urandom_range(0, 99) < 30, (i < 1500) ? LINE_W'($urandom_range(0, 11)) : LINE_W'($urandom),
            $urandom_range(0, 99) < 60, $urandom_range(0, 99) < 35);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule